// File: doc/BRIEF.md
# Ping-Pong Page Writer for a Dual-Buffer Serial Flash

This block is an SPI master (mode 0: clock idles low, the device samples on the rising edge, MSB first). It turns an incoming byte stream into page programs on a serial flash that has two internal page buffers. A session starts with a pulse on `start` and a starting page number. The writer loads one device buffer with a buffer-write frame, checks that the device is idle, and then sends a program-with-erase frame for that buffer. It then starts loading the other buffer at once, so loading overlaps the self-timed program of the first buffer. Before each program command it polls the device status.

The byte stream uses valid/ready. A byte moves on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is high only while a buffer-write frame is waiting for its next payload byte. While the source holds `in_valid` low, the frame pauses: chip select stays low and the SPI clock stays low. A byte with `in_last` set ends the stream. Any bytes still missing from the current page are sent as FFh, that page is programmed, and the session closes.

Top module: `pingpong_flash_writer`

## Requirements
- R1: A buffer-write frame is sent with chip select low. It carries the opcode, then three 00h address bytes (start address 0), then exactly PAGE_BYTES payload bytes. Every byte goes out MSB first, with `sclk` idle low and `mosi` held steady while `sclk` is high.
- R2: The opcode is 84h when loading device buffer 1 and 87h when loading buffer 2. Every session starts with buffer 1, and the two buffers alternate from page to page.
- R3: A program frame is four bytes. The first is 83h (buffer 1) or 86h (buffer 2), naming the buffer that was just loaded. The other three hold the 24-bit word {4'b0, 11-bit page, 9'b0}, most significant byte first.
- R4: A status poll frame is D7h followed by one dummy 00h byte, during which the writer reads `miso`. The first bit read is bit 7, and 1 means ready. The writer sends a program frame only straight after a poll that read ready. While polls read busy, it repeats the poll frame.
- R5: The buffer-write frame for the next page comes straight after a program frame, with no poll between them.
- R6: The first program of a session uses `start_page`. Each later program uses the page number plus one, wrapping from 2^PAGE_W-1 to 0.
- R7: If `in_last` arrives partway through a page, the rest of that page is sent as FFh. After that page's program frame, `active` drops, `in_ready` stays low and `cs_n` stays high.
- R8: Between any two frames, `cs_n` stays high for at least two SPI clock periods (4*CLK_DIV clock cycles). `sclk` is low whenever `cs_n` is high.
- R9: When `in_ready` is high, `cs_n` is low and `sclk` is low. The frame does not advance until a byte is accepted.
- R10: After reset, `cs_n`=1, `sclk`=0, `in_ready`=0 and `active`=0. A `start` pulse while `active` is high is ignored, and the running session keeps its page sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a session (ignored while active) |
| start_page | input | PAGE_W | First page to program |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final stream byte |
| in_ready | output | 1 | Writer accepts a stream byte |
| active | output | 1 | Session in progress |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | Device select, active low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |

## Verification
The bench builds the writer with PAGE_BYTES=4, PAGE_W=2 and CLK_DIV=2. With pages this small, a session of a dozen bytes covers the page number wrapping from 3 to 0, padding with FFh, a stream that ends exactly on a page boundary, and several pages in a row with alternating buffers, all in a few thousand cycles. A flash model in the bench decodes every frame and answers busy to a chosen number of polls after each program. This exercises repeated polling and also covers busy time left over from the previous session. Gaps inserted into `in_valid` exercise the paused frame.

// File: rtl/pp_flash_pkg.sv
package pp_flash_pkg;
  localparam logic [7:0] OPC_LOAD_B1 = 8'h84;
  localparam logic [7:0] OPC_LOAD_B2 = 8'h87;
  localparam logic [7:0] OPC_PROG_B1 = 8'h83;
  localparam logic [7:0] OPC_PROG_B2 = 8'h86;
  localparam logic [7:0] OPC_STATUS  = 8'hD7;
  localparam logic [7:0] PAD_BYTE    = 8'hFF;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA, ST_GAP} wr_state_t;
  typedef enum logic [1:0] {OP_FILL, OP_POLL, OP_PROG} wr_op_t;
endpackage

// File: rtl/pp_spi_shifter.sv
module pp_spi_shifter #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic       rx_msb
);
  localparam int DIV_W = $clog2(CLK_DIV) + 1;

  logic             run;
  logic [2:0]       bit_idx;
  logic [DIV_W-1:0] div_cnt;
  logic [7:0]       sh;

  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; bit_idx <= '0; div_cnt <= '0; sh <= '0;
      sclk <= 1'b0; done <= 1'b0; rx_msb <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        if (go) begin
          run <= 1'b1; sh <= tx_byte; bit_idx <= '0; div_cnt <= '0; sclk <= 1'b0;
        end
      end else if (div_cnt == DIV_W'(CLK_DIV - 1)) begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          if (bit_idx == 3'd0) rx_msb <= miso;
        end else begin
          sclk <= 1'b0;
          sh   <= {sh[6:0], 1'b1};
          if (bit_idx == 3'd7) begin
            run  <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 3'd1;
          end
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/pp_gap_timer.sv
module pp_gap_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CYCLES) + 1;
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!expired) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/pingpong_flash_writer.sv
module pingpong_flash_writer
  import pp_flash_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_W     = 11,
  parameter int CLK_DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] start_page,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              active,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int CNT_W   = $clog2(PAGE_BYTES) + 1;
  localparam int GAP_CYC = 4 * CLK_DIV;

  wr_state_t         state;
  wr_op_t            op;
  logic [1:0]        hdr_idx;
  logic [CNT_W-1:0]  byte_cnt;
  logic [PAGE_W-1:0] page;
  logic              buf_sel;
  logic              ended;
  logic              launched;
  logic              ready_q;

  logic       go;
  logic [7:0] tx_byte;
  logic [7:0] hdr_byte;
  logic       sh_done;
  logic       sh_rx_msb;
  logic       gap_done;
  logic       hdr_last;
  logic [23:0] prog_addr;

  assign prog_addr = {4'b0000, 11'(page), 9'd0};
  assign hdr_last  = (op == OP_POLL) ? (hdr_idx == 2'd1) : (hdr_idx == 2'd3);
  assign active    = (state != ST_IDLE);
  assign cs_n      = (state == ST_IDLE) || (state == ST_GAP);

  always_comb begin
    hdr_byte = 8'h00;
    unique case (op)
      OP_FILL: if (hdr_idx == 2'd0) hdr_byte = buf_sel ? OPC_LOAD_B2 : OPC_LOAD_B1;
      OP_POLL: if (hdr_idx == 2'd0) hdr_byte = OPC_STATUS;
      default: begin
        unique case (hdr_idx)
          2'd0:    hdr_byte = buf_sel ? OPC_PROG_B2 : OPC_PROG_B1;
          2'd1:    hdr_byte = prog_addr[23:16];
          2'd2:    hdr_byte = prog_addr[15:8];
          default: hdr_byte = prog_addr[7:0];
        endcase
      end
    endcase
  end

  always_comb begin
    go = 1'b0; tx_byte = 8'h00; in_ready = 1'b0;
    if (!launched) begin
      if (state == ST_HDR) begin
        go = 1'b1; tx_byte = hdr_byte;
      end else if (state == ST_DATA) begin
        if (ended) begin
          go = 1'b1; tx_byte = PAD_BYTE;
        end else begin
          in_ready = 1'b1;
          if (in_valid) begin go = 1'b1; tx_byte = in_data; end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; op <= OP_FILL; hdr_idx <= '0; byte_cnt <= '0;
      page <= '0; buf_sel <= 1'b0; ended <= 1'b0; launched <= 1'b0; ready_q <= 1'b0;
    end else begin
      if (go) launched <= 1'b1;
      if (in_ready && in_valid && in_last) ended <= 1'b1;
      unique case (state)
        ST_IDLE: if (start) begin
          page <= start_page; buf_sel <= 1'b0; ended <= 1'b0;
          op <= OP_FILL; hdr_idx <= '0; state <= ST_HDR;
        end
        ST_HDR: if (sh_done) begin
          launched <= 1'b0;
          if (!hdr_last) begin
            hdr_idx <= hdr_idx + 2'd1;
          end else begin
            hdr_idx <= '0;
            unique case (op)
              OP_FILL: begin state <= ST_DATA; byte_cnt <= '0; end
              OP_POLL: begin ready_q <= sh_rx_msb; state <= ST_GAP; end
              default: begin page <= page + PAGE_W'(1); buf_sel <= ~buf_sel; state <= ST_GAP; end
            endcase
          end
        end
        ST_DATA: if (sh_done) begin
          launched <= 1'b0;
          if (byte_cnt == CNT_W'(PAGE_BYTES - 1)) state <= ST_GAP;
          else byte_cnt <= byte_cnt + CNT_W'(1);
        end
        default: if (gap_done) begin
          unique case (op)
            OP_FILL: begin op <= OP_POLL; state <= ST_HDR; end
            OP_POLL: begin op <= ready_q ? OP_PROG : OP_POLL; state <= ST_HDR; end
            default: begin
              if (ended) state <= ST_IDLE;
              else begin op <= OP_FILL; state <= ST_HDR; end
            end
          endcase
        end
      endcase
    end
  end

  pp_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(go), .tx_byte(tx_byte), .miso(miso),
    .sclk(sclk), .mosi(mosi), .done(sh_done), .rx_msb(sh_rx_msb)
  );

  pp_gap_timer #(.CYCLES(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .run(state == ST_GAP), .expired(gap_done)
  );
endmodule

// File: rtl/pp_writer_checker.sv
module pp_writer_checker #(
  parameter int CLK_DIV = 2
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic in_valid,
  input logic in_ready,
  input logic active,
  input logic sclk,
  input logic cs_n,
  input logic mosi
);
  localparam int GAP_CYC = 4 * CLK_DIV;
  localparam int HW = $clog2(GAP_CYC + 1) + 1;

  logic [HW-1:0] hi_cnt;
  logic          seen_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0; seen_frame <= 1'b0;
    end else begin
      if (!cs_n) begin hi_cnt <= '0; seen_frame <= 1'b1; end
      else if (hi_cnt < HW'(GAP_CYC)) hi_cnt <= hi_cnt + HW'(1);
    end
  end

  // R8: clock parked low while deselected
  a_r8_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  // R8: minimum deselect time between frames
  a_r8_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && seen_frame) |-> (hi_cnt >= HW'(GAP_CYC)));

  // R9: a waiting payload slot pauses the frame
  a_r9_ready_paused: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!cs_n && !sclk));

  // R10: stream only accepted inside a session
  a_r10_ready_in_session: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> active);

  // R10: a session only opens on a start request
  a_r10_session_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(start));

  // R1: data steady through the high phase of sclk
  a_r1_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  logic unused_ok;
  assign unused_ok = in_valid;
endmodule

bind pingpong_flash_writer pp_writer_checker #(.CLK_DIV(CLK_DIV)) u_writer_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_ready(in_ready),
  .active(active), .sclk(sclk), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/test_pingpong_flash_writer.sv
`timescale 1ns/1ps
module test_pingpong_flash_writer;
  localparam int PB   = 4;
  localparam int PW   = 2;
  localparam int DIV  = 2;
  localparam int NPG  = 1 << PW;
  localparam int GAPC = 4 * DIV;
  localparam int NVEC = 5;
  // fields: {bytes, start page, busy polls, stall cycles}
  localparam logic [31:0] VEC [0:NVEC-1] = '{
    {8'd8,  8'd0, 8'd0, 8'd0},
    {8'd6,  8'd1, 8'd2, 8'd3},
    {8'd13, 8'd2, 8'd1, 8'd0},
    {8'd1,  8'd3, 8'd3, 8'd2},
    {8'd4,  8'd3, 8'd0, 8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PW-1:0] start_page = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_last = 1'b0;
  logic in_ready, active, sclk, cs_n, mosi, miso;

  always #2.5 clk = ~clk;

  pingpong_flash_writer #(.PAGE_BYTES(PB), .PAGE_W(PW), .CLK_DIV(DIV)) i_pingpong_flash_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .active(active), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int fails = 0;

  // ---------------- flash model ----------------
  logic [7:0] m_sh = 8'h00;
  logic [7:0] m_op = 8'h00;
  int m_bits = 0;
  int busy_left = 0;
  int busy_k = 0;
  int nfr = 0;
  logic [7:0] fb [0:63][0:7];
  int flen [0:63];

  assign miso = !cs_n && (m_bits >= 8) && (m_op == 8'hD7) && (busy_left == 0);

  always @(posedge sclk or posedge cs_n) begin
    if (cs_n) begin
      if (m_bits > 0) begin
        if (nfr < 64) flen[nfr] = m_bits / 8;
        if (m_op == 8'h83 || m_op == 8'h86) busy_left = busy_k;
        else if (m_op == 8'hD7 && busy_left > 0) busy_left = busy_left - 1;
        nfr = nfr + 1;
      end
      m_bits = 0;
    end else begin
      m_sh = {m_sh[6:0], mosi};
      if (m_bits % 8 == 7) begin
        if (nfr < 64 && m_bits / 8 < 8) fb[nfr][m_bits/8] = m_sh;
        if (m_bits == 7) m_op = m_sh;
      end
      m_bits = m_bits + 1;
    end
  end

  // ---------------- pin monitors (R8, R9) ----------------
  int hi_run = 0;
  bit seen_low = 0;
  int err_gap = 0;
  int err_pause = 0;
  logic cs_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_prev && !cs_n) begin
        if (seen_low && hi_run < GAPC) err_gap++;
        seen_low = 1;
      end
      if (cs_n && sclk) err_gap++;
      if (in_ready && (cs_n || sclk)) err_pause++;
      hi_run = cs_n ? hi_run + 1 : 0;
      cs_prev = cs_n;
    end
  end

  // ---------------- expected frames ----------------
  logic [7:0] eb [0:63][0:7];
  int elen [0:63];
  string etag [0:63];
  int ne;
  int prev_k = 0;

  function automatic logic [7:0] dbyte(input int v, input int i);
    return 8'((v * 37 + i * 5 + 1) % 128);
  endfunction

  task automatic push_frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                            input logic [7:0] b3, input int len, input string tag);
    eb[ne][0] = b0; eb[ne][1] = b1; eb[ne][2] = b2; eb[ne][3] = b3;
    elen[ne] = len; etag[ne] = tag; ne++;
  endtask

  task automatic build_expected(input int n, input int p, input int k, input int v);
    int pages;
    pages = (n + PB - 1) / PB;
    ne = 0;
    for (int pg = 0; pg < pages; pg++) begin
      int bsel;
      int polls;
      logic [23:0] pa;
      bsel = pg % 2;
      push_frame(bsel ? 8'h87 : 8'h84, 8'h00, 8'h00, 8'h00, 4 + PB,
                 (pg == 0) ? "R1 R2 R7" : "R1 R2 R5 R7");
      for (int i = 0; i < PB; i++)
        eb[ne-1][4+i] = (pg * PB + i < n) ? dbyte(v, pg * PB + i) : 8'hFF;
      polls = ((pg == 0) ? prev_k : k) + 1;
      for (int q = 0; q < polls; q++) push_frame(8'hD7, 8'h00, 8'h00, 8'h00, 2, "R4");
      pa = {4'b0000, 11'((p + pg) % NPG), 9'd0};
      push_frame(bsel ? 8'h86 : 8'h83, pa[23:16], pa[15:8], pa[7:0], 4, "R3 R6");
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_frames(input int base);
    chk(nfr - base == ne, "R4 R5 frame count", nfr - base, ne);
    for (int f = 0; f < ne && base + f < 64; f++) begin
      int bad;
      bad = -1;
      if (flen[base+f] != elen[f]) bad = 99;
      else for (int b = 0; b < elen[f]; b++) if (bad < 0 && fb[base+f][b] != eb[f][b]) bad = b;
      if (bad == 99) chk(1'b0, {etag[f], " frame length"}, flen[base+f], elen[f]);
      else if (bad >= 0) chk(1'b0, {etag[f], " frame byte"}, fb[base+f][bad], eb[f][bad]);
      else chk(1'b1, etag[f], 0, 0);
    end
  endtask

  task automatic stream(input int n, input int v, input int stall);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = dbyte(v, i); in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      repeat (stall) @(negedge clk);
    end
  endtask

  task automatic run_session(input int n, input int p, input int k, input int stall,
                             input int v, input bit restart);
    int base;
    busy_k = k;
    base = nfr;
    build_expected(n, p, k, v);
    @(negedge clk); start = 1'b1; start_page = PW'(p);
    @(negedge clk); start = 1'b0;
    fork
      stream(n, v, stall);
      if (restart) begin
        repeat (60) @(negedge clk);
        start = 1'b1; start_page = PW'(p + 2);
        @(negedge clk); start = 1'b0;
      end
    join
    while (active) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(!active && !in_ready && cs_n, "R7 session closed", {active, in_ready, cs_n}, 3'b001);
    compare_frames(base);
    prev_k = k;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cs_n == 1'b1, "R10 reset cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R10 reset sclk", sclk, 0);
    chk(in_ready == 1'b0, "R10 reset in_ready", in_ready, 0);
    chk(active == 1'b0, "R10 reset active", active, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      run_session(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]),
                  int'(VEC[v][7:0]), v, 1'b0);
    end

    // R10: start while active must not disturb the page sequence
    run_session(5, 1, 1, 1, 5, 1'b1);

    // R8 / R9 pin-level rules over the whole run
    chk(err_gap == 0, "R8 deselect gap", err_gap, 0);
    chk(err_pause == 0, "R9 paused frame", err_pause, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule